// File: doc/BRIEF.md
# Spawn-Join Thread Dispatcher

This block moves a group of thread units between a serial mode, in which only unit 0 runs, and a parallel mode, in which every unit executes virtual threads of one spawned job. A spawn command carries a thread count n. On it, each unit starts on the virtual thread whose number equals its own unit index, provided that number is below n. A unit that finishes a thread pulls the next thread number from a shared counter with fetch-and-add semantics, so a free unit never waits for the rest of the first wave.

A unit whose fresh number is n or above retires and stays idle until the next spawn. When no unit is running, the dispatcher drops back to serial mode and raises a one-cycle completion pulse. When several units finish in the same cycle, the counter serves all of them within that cycle, in ascending unit order.

Top module: `thread_dispatch`

## Requirements
- R1: After reset the dispatcher is in serial mode (`par_mode`=0), `unit_enable`=0x01 and `join_done`=0.
- R2: A spawn (`spawn_valid`=1) accepted in serial mode sets `par_mode` at the next edge. At that edge each unit i gets thread number i and is enabled exactly when i < n.
- R3: A spawn presented while in parallel mode has no effect on mode, thread numbers, enables or the counter.
- R4: The shared counter holds T after a spawn. A running unit that pulses `unit_finish` takes the counter value as its new thread number at the next edge. Units finishing in the same cycle take consecutive numbers in ascending unit-index order, and the counter advances by the number of such units.
- R5: A unit whose new thread number is n or above drops its enable and stays idle until the next spawn. A `unit_finish` pulse from an idle unit is ignored and consumes no number.
- R6: One edge after the edge at which no unit is left running, `par_mode` clears and `join_done` is high for exactly one cycle.
- R7: A spawn with n = 0 enables no unit: parallel mode lasts one cycle and serial mode resumes with the completion pulse.
- R8: In serial mode `unit_enable` is 0x01 and `unit_finish` pulses have no effect.
- R9: Each thread number from 0 to n-1 is started exactly once per spawn, whatever the finishing order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spawn_valid | input | 1 | Spawn command strobe |
| spawn_count | input | 16 | Number n of virtual threads in the spawn |
| unit_finish | input | 8 | Per-unit pulse: the unit completed its current thread |
| par_mode | output | 1 | 1 while in parallel mode |
| unit_enable | output | 8 | Per-unit run enable (unit 0 only in serial mode) |
| unit_tid | output | 136 | Thread number per unit, 17 bits each, unit i at bits [17i+16:17i] |
| join_done | output | 1 | One-cycle pulse when serial mode resumes |

## Verification
The hardest situation to reach is several units finishing in the same cycle while the counter crosses n. Here some of the simultaneous finishers must take in-range numbers in unit order and the others must retire at once. The stimulus gets there by running thread units with zero run length, so all eight finish together every cycle with a count that is not a multiple of eight. Mixed random run lengths, stray finish pulses from idle units and spawns issued mid-job cover the ordering and ignore cases. A per-number tally confirms that each thread was started exactly once.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;
   typedef enum logic {
      MODE_SERIAL   = 1'b0,
      MODE_PARALLEL = 1'b1
   } mode_e;
endpackage

// File: rtl/tdisp_mode_fsm.sv
module tdisp_mode_fsm
   import tdisp_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  spawn_valid,
   input  logic  any_run,
   output mode_e mode,
   output logic  launch,
   output logic  done
);
   // A spawn is only taken in serial mode; in parallel mode it is dropped.
   assign launch = (mode == MODE_SERIAL) && spawn_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MODE_SERIAL;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (mode)
            MODE_SERIAL: begin
               if (spawn_valid) mode <= MODE_PARALLEL;
            end
            MODE_PARALLEL: begin
               if (!any_run) begin
                  mode <= MODE_SERIAL;
                  done <= 1'b1;
               end
            end
            default: mode <= MODE_SERIAL;
         endcase
      end
   end
endmodule

// File: rtl/tdisp_id_alloc.sv
module tdisp_id_alloc #(
   parameter int UNITS = 8,
   parameter int ID_W  = 17
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       launch,
   input  logic [UNITS-1:0]           req,
   output logic [UNITS-1:0][ID_W-1:0] grant_id
);
   logic [ID_W-1:0] ctr_q;
   logic [ID_W-1:0] ctr_nxt;

   // Fetch-and-add for all requesters at once: each one sees the running
   // total of the lower-indexed requesters added to the counter.
   always_comb begin
      ctr_nxt = ctr_q;
      for (int i = 0; i < UNITS; i++) begin
         grant_id[i] = ctr_nxt;
         if (req[i]) ctr_nxt = ctr_nxt + ID_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctr_q <= ID_W'(UNITS);
      else if (launch) ctr_q <= ID_W'(UNITS);
      else             ctr_q <= ctr_nxt;
   end
endmodule

// File: rtl/tdisp_unit_slot.sv
module tdisp_unit_slot #(
   parameter int IDX   = 0,
   parameter int CNT_W = 16,
   parameter int ID_W  = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic [CNT_W-1:0] spawn_count,
   input  logic [CNT_W-1:0] n_limit,
   input  logic             grant,
   input  logic [ID_W-1:0]  grant_id,
   output logic             run,
   output logic [ID_W-1:0]  tid
);
   localparam logic [ID_W-1:0] FIRST_ID = ID_W'(IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         tid <= FIRST_ID;
      end else if (launch) begin
         tid <= FIRST_ID;
         run <= FIRST_ID < ID_W'(spawn_count);
      end else if (grant) begin
         tid <= grant_id;
         run <= grant_id < ID_W'(n_limit);
      end
   end
endmodule

// File: rtl/thread_dispatch.sv
module thread_dispatch
   import tdisp_pkg::*;
#(
   parameter int NUM_UNITS = 8,
   parameter int CNT_W     = 16,
   localparam int ID_W     = CNT_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      spawn_valid,
   input  logic [CNT_W-1:0]          spawn_count,
   input  logic [NUM_UNITS-1:0]      unit_finish,
   output logic                      par_mode,
   output logic [NUM_UNITS-1:0]      unit_enable,
   output logic [NUM_UNITS*ID_W-1:0] unit_tid,
   output logic                      join_done
);
   generate
      if (NUM_UNITS < 1) begin : g_bad_units
         $error("thread_dispatch: NUM_UNITS must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 30) begin : g_bad_width
         $error("thread_dispatch: CNT_W must lie in 1..30");
      end
      if (CNT_W < 31 && (2 * NUM_UNITS) > (1 << CNT_W)) begin : g_bad_ratio
         $error("thread_dispatch: counter headroom too small for NUM_UNITS");
      end
   endgenerate

   mode_e                           mode;
   logic                            launch;
   logic                            any_run;
   logic [NUM_UNITS-1:0]            run;
   logic [NUM_UNITS-1:0]            req;
   logic [NUM_UNITS-1:0][ID_W-1:0]  grant_id;
   logic [CNT_W-1:0]                n_q;

   assign any_run  = |run;
   assign par_mode = (mode == MODE_PARALLEL);
   assign req      = par_mode ? (unit_finish & run) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      n_q <= '0;
      else if (launch) n_q <= spawn_count;
   end

   tdisp_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .spawn_valid (spawn_valid),
      .any_run     (any_run),
      .mode        (mode),
      .launch      (launch),
      .done        (join_done)
   );

   tdisp_id_alloc #(.UNITS(NUM_UNITS), .ID_W(ID_W)) u_alloc (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .req      (req),
      .grant_id (grant_id)
   );

   generate
      for (genvar g = 0; g < NUM_UNITS; g++) begin : g_slot
         tdisp_unit_slot #(.IDX(g), .CNT_W(CNT_W), .ID_W(ID_W)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .launch      (launch),
            .spawn_count (spawn_count),
            .n_limit     (n_q),
            .grant       (req[g]),
            .grant_id    (grant_id[g]),
            .run         (run[g]),
            .tid         (unit_tid[g*ID_W +: ID_W])
         );
         if (g == 0) begin : g_lead
            assign unit_enable[g] = par_mode ? run[g] : 1'b1;
         end else begin : g_rest
            assign unit_enable[g] = par_mode & run[g];
         end
      end
   endgenerate
endmodule

// File: rtl/tdisp_checker.sv
module tdisp_checker #(
   parameter int NUM_UNITS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 spawn_valid,
   input logic                 par_mode,
   input logic                 join_done,
   input logic [NUM_UNITS-1:0] unit_enable
);
   localparam logic [NUM_UNITS-1:0] LEAD_ONLY = NUM_UNITS'(1);

   a_r1_reset_serial: assert property (@(posedge clk)
      !rst_n |=> (!par_mode && !join_done));

   a_r2_spawn_enters: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_mode && spawn_valid) |=> par_mode);

   a_r3_busy_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (par_mode && unit_enable != '0) |=> par_mode);

   a_r5_no_wake_midjob: assert property (@(posedge clk) disable iff (!rst_n)
      (par_mode && $past(par_mode)) |-> ((unit_enable & ~$past(unit_enable)) == '0));

   a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      join_done |=> !join_done);

   a_r6_exit_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(par_mode) |-> join_done);

   a_r8_serial_lead: assert property (@(posedge clk) disable iff (!rst_n)
      !par_mode |-> (unit_enable == LEAD_ONLY));
endmodule

bind thread_dispatch tdisp_checker #(.NUM_UNITS(NUM_UNITS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .spawn_valid (spawn_valid),
   .par_mode    (par_mode),
   .join_done   (join_done),
   .unit_enable (unit_enable)
);

// File: tb/sim_thread_dispatch.sv
`timescale 1ns/1ps
module sim_thread_dispatch;
   localparam int T    = 8;
   localparam int CW   = 16;
   localparam int IW   = CW + 1;
   localparam int MAXN = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              spawn_valid = 1'b0;
   logic [CW-1:0]     spawn_count = '0;
   logic [T-1:0]      unit_finish = '0;
   logic              par_mode;
   logic [T-1:0]      unit_enable;
   logic [T*IW-1:0]   unit_tid;
   logic              join_done;

   always #2.5 clk = ~clk;

   thread_dispatch #(.NUM_UNITS(T), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .spawn_valid(spawn_valid), .spawn_count(spawn_count),
      .unit_finish(unit_finish), .par_mode(par_mode), .unit_enable(unit_enable),
      .unit_tid(unit_tid), .join_done(join_done)
   );

   typedef struct {
      int           due;
      bit           is_mode;
      int           unit;
      int           id;
      bit           en;
      bit           par;
      bit           done;
      logic [T-1:0] mask;
      string        req;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic push_mode(int due, bit par, bit done, logic [T-1:0] mask, string req);
      exp_t e;
      e.due = due; e.is_mode = 1; e.unit = 0; e.id = 0; e.en = 0;
      e.par = par; e.done = done; e.mask = mask; e.req = req;
      q.push_back(e);
   endtask

   task automatic push_unit(int due, int unit, int id, bit en, string req);
      exp_t e;
      e.due = due; e.is_mode = 0; e.unit = unit; e.id = id; e.en = en;
      e.par = 1; e.done = 0; e.mask = '0; e.req = req;
      q.push_back(e);
   endtask

   // Monitor: compares every item whose due cycle has arrived.
   always @(posedge clk) begin
      #1;
      for (int k = q.size() - 1; k >= 0; k--) begin
         if (q[k].due == cyc) begin
            exp_t e;
            e = q[k];
            q.delete(k);
            n_cmp++;
            if (e.is_mode) begin
               if (par_mode !== e.par || join_done !== e.done || unit_enable !== e.mask) begin
                  n_bad++;
                  $display("FAIL %s cyc %0d: par/done/enable got %b/%b/%b exp %b/%b/%b",
                           e.req, cyc, par_mode, join_done, unit_enable, e.par, e.done, e.mask);
               end
            end else begin
               if (unit_enable[e.unit] !== e.en ||
                   (e.en && unit_tid[e.unit*IW +: IW] !== IW'(e.id))) begin
                  n_bad++;
                  $display("FAIL %s cyc %0d unit %0d: en/tid got %b/%0d exp %b/%0d",
                           e.req, cyc, e.unit, unit_enable[e.unit],
                           unit_tid[e.unit*IW +: IW], e.en, e.id);
               end
            end
         end
      end
   end

   int exp_ctr;
   int seen[MAXN];
   int rem[T];

   task automatic check_tally(int n);
      for (int id = 0; id < n; id++) begin
         n_cmp++;
         if (seen[id] != 1) begin
            n_bad++;
            $display("FAIL R9 n=%0d: thread %0d started %0d times exp 1", n, id, seen[id]);
         end
      end
   endtask

   // Driver: issues a spawn and models thread units of given run lengths.
   task automatic run_spawn(int n, int max_len, bit noise);
      logic [T-1:0] exp_run;
      logic [T-1:0] fin;
      int c;
      for (int i = 0; i < MAXN; i++) seen[i] = 0;
      @(negedge clk);
      c = cyc;
      spawn_valid = 1'b1;
      spawn_count = CW'(n);
      exp_run = '0;
      for (int i = 0; i < T; i++) begin
         if (i < n) begin
            exp_run[i] = 1'b1;
            seen[i]++;
            push_unit(c + 1, i, i, 1'b1, "R2");
         end
         rem[i] = $urandom_range(0, max_len);
      end
      push_mode(c + 1, 1'b1, 1'b0, exp_run, "R2");
      exp_ctr = T;
      if (exp_run == '0) begin
         push_mode(c + 2, 1'b0, 1'b1, T'(1), "R7");
         push_mode(c + 3, 1'b0, 1'b0, T'(1), "R7");
      end else begin
         forever begin
            @(negedge clk);
            c = cyc;
            spawn_valid = 1'b0;
            if (noise && ($urandom_range(0, 5) == 0)) begin
               spawn_valid = 1'b1;              // R3: ignored mid-job
               spawn_count = CW'($urandom_range(1, 30));
            end
            fin = '0;
            for (int i = 0; i < T; i++) begin
               if (exp_run[i]) begin
                  if (rem[i] == 0) fin[i] = 1'b1;
                  else rem[i]--;
               end else if (noise && ($urandom_range(0, 3) == 0)) begin
                  fin[i] = 1'b1;                // R5: idle pulse ignored
               end
            end
            unit_finish = fin;
            for (int i = 0; i < T; i++) begin
               if (fin[i] && exp_run[i]) begin
                  bit en;
                  en = (exp_ctr < n);
                  push_unit(c + 1, i, exp_ctr, en, en ? "R4" : "R5");
                  if (en) begin
                     seen[exp_ctr]++;
                     rem[i] = $urandom_range(0, max_len);
                  end
                  exp_run[i] = en;
                  exp_ctr++;
               end
            end
            if (exp_run == '0) begin
               push_mode(c + 1, 1'b1, 1'b0, '0, "R6");
               push_mode(c + 2, 1'b0, 1'b1, T'(1), "R6");
               push_mode(c + 3, 1'b0, 1'b0, T'(1), "R6");
               break;
            end
         end
      end
      @(negedge clk);
      spawn_valid = 1'b0;
      unit_finish = '0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      check_tally(n);
   endtask

   task automatic serial_idle(int cycles);
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         unit_finish = T'($urandom());
         push_mode(cyc + 1, 1'b0, 1'b0, T'(1), "R8");
      end
      @(negedge clk);
      unit_finish = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      n_cmp++;
      if (par_mode !== 1'b0 || join_done !== 1'b0 || unit_enable !== T'(1)) begin
         n_bad++;
         $display("FAIL R1: par/done/enable got %b/%b/%b exp 0/0/00000001",
                  par_mode, join_done, unit_enable);
      end
      rst_n = 1'b1;
      serial_idle(4);
      run_spawn(3, 3, 1'b0);     // fewer threads than units
      run_spawn(8, 2, 1'b0);     // exactly one per unit
      run_spawn(0, 2, 1'b0);     // R7
      run_spawn(20, 0, 1'b0);    // all finish together, counter crosses n mid-group
      run_spawn(37, 4, 1'b1);    // mixed lengths, stray pulses, ignored spawns
      serial_idle(3);
      run_spawn(9, 0, 1'b0);
      run_spawn(1, 5, 1'b1);
      run_spawn(50, 6, 1'b1);
      serial_idle(2);
      repeat (4) @(negedge clk);
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: %0d items left exp 0", q.size());
      end
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      finish_run();
   end
endmodule